// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a pipelined synchronous SRAM whose data bus never idles when traffic switches between reads and writes. A read returns its word on the registered output one active clock edge after the command edge. A write takes its data two active edges after the command edge. Because the write data slot lines up with the read data slot, a read may follow a write (or the reverse) on every cycle with no dead cycle in between.

Commands are sampled on rising edges whenever the active-low clock enable is low. A load (advance/load low) latches a fresh address, or retires the burst when chip select is inactive. An advance (advance/load high) repeats the previous operation at the next address of a four-beat wrapping burst, in linear or interleaved order. Four active-low lane enables mask writes, each covering 18 bits of the 72-bit word. A read that hits a write still waiting for its data returns the merged pending data. An output enable gates the read data combinationally. A sleep input blocks new commands after a two-edge delay and releases them two edges after it drops, keeping the array contents.

Top module: `zt_sram`

## Requirements
- R1: While `rst_n` is low at an edge, pending operations, the output-valid state and the burst state are cleared. Afterwards `rdata_oe` is 0, and an advance issued before any load does nothing.
- R2: At an edge where `cke_n` is high, all synchronous inputs except `zz` and `rst_n` are ignored. The output, the pipeline, the burst state and the array hold their values. An "active edge" below is an edge with `cke_n` low.
- R3: A load is an active edge with `adv_ld` low. With `cs_n` low it starts a new operation at `addr` (`we_n` low: write, high: read). With `cs_n` high it is a deselect: no operation, the burst ends, and `rdata_oe` is 0 after the next active edge.
- R4: A read issued at active edge n puts the array word on `rdata`, with `rdata_oe` high, after active edge n+1. The word holds until the following active edge.
- R5: A write issued at active edge n samples `wdata` at active edge n+2. Lane i, bits [18i+17:18i], is written only if `bw_n[i]` was 0 at edge n.
- R6: A read issued at the active edge directly after a write to the same address returns that write's `wdata`, which is sampled at the read's output edge, in the enabled lanes, and the old contents in the other lanes.
- R7: `rdata` and `rdata_oe` are 0 whenever `oe_n` is high. The gating is combinational and takes effect with no clock edge.
- R8: With `lin_order` = 1, the k-th advance after a load (k = 1..3, then wrapping back to the base) uses the address whose two low bits are (base + k) mod 4. The upper bits are unchanged.
- R9: With `lin_order` = 0, the k-th advance uses the low bits base XOR (k mod 4). The upper bits are unchanged.
- R10: An advance repeats the read or write type of the last load and takes `bw_n` from the advance edge. After a deselect or reset, an advance is a no-operation.
- R11: `zz` is sampled at every edge, including edges with `cke_n` high. A command at an active edge is turned into a no-operation, and leaves the burst state alone, if `zz` was high two edges earlier. Operations already issued still complete, and the array is kept.
- R12: Reads and writes may alternate on consecutive active edges with no idle cycle, and every result still obeys R4 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low |
| adv_ld | input | 1 | 1: advance burst, 0: load new command |
| cs_n | input | 1 | Chip select on load, active low; high means deselect |
| we_n | input | 1 | Write enable on load, active low |
| bw_n | input | LANES | Lane write enables, active low |
| addr | input | AW | Word address |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| zz | input | 1 | Sleep request |
| oe_n | input | 1 | Output enable, active low, combinational |
| wdata | input | DW | Write data, sampled two active edges after the command |
| rdata | output | DW | Read data, zero when not driven |
| rdata_oe | output | 1 | High while rdata carries a read word |

## Verification
The sharpest case is a read issued right after a write to the same address. A design without the forwarding path returns stale array data there, and one that forwards unmasked lanes corrupts the untouched ones. Bursts are started from every low-bit offset in both orders and run past four beats. A wrong wrap or order sends the later beats to the wrong words, which later reads expose. Random clock-enable stalls, deselects followed by advances, output-enable toggling and sleep windows are mixed into streams of alternating reads and writes. An off-by-one in the sleep delay, or a write that samples its data at the wrong edge during a stall, then shows up as a mismatch against the cycle model.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int DW    = 72,
  parameter int LANES = 4,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             adv_ld,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  input  logic             lin_order,
  input  logic             zz,
  input  logic             oe_n,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);
  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic zz_q1, zz_q2;

  logic          b_act, b_we;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  logic             s1_v, s1_we, s2_v, s2_we;
  logic [AW-1:0]    s1_a, s2_a;
  logic [LANES-1:0] s1_bw, s2_bw;

  logic          r_v;
  logic [DW-1:0] r_d, fwd;

  wire go  = !cke_n;
  wire ld  = !adv_ld && !zz_q2;
  wire adv = adv_ld && !zz_q2 && b_act;

  wire [1:0]    nxt_cnt = b_cnt + 2'd1;
  wire [1:0]    nxt_lo  = lin_order ? (b_base[1:0] + nxt_cnt) : (b_base[1:0] ^ nxt_cnt);
  wire [AW-1:0] adv_a   = {b_base[AW-1:2], nxt_lo};

  wire          new_v  = (ld && !cs_n) || adv;
  wire          new_we = ld ? !we_n : b_we;
  wire [AW-1:0] new_a  = ld ? addr : adv_a;
  wire          s2_wr  = s2_v && s2_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zz_q1 <= 1'b0;
      zz_q2 <= 1'b0;
    end else begin
      zz_q1 <= zz;
      zz_q2 <= zz_q1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_act <= 1'b0;
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
      r_v   <= 1'b0;
    end else if (go) begin
      if (ld) begin
        b_act  <= !cs_n;
        b_we   <= !we_n;
        b_base <= addr;
        b_cnt  <= 2'd0;
      end else if (adv) begin
        b_cnt <= nxt_cnt;
      end
      s1_v  <= new_v;
      s1_we <= new_we;
      s1_a  <= new_a;
      s1_bw <= ~bw_n;
      s2_v  <= s1_v;
      s2_we <= s1_we;
      s2_a  <= s1_a;
      s2_bw <= s1_bw;
      r_v   <= s1_v && !s1_we;
      r_d   <= fwd;
    end
  end

  always_comb begin
    fwd = mem[s1_a];
    for (int i = 0; i < LANES; i++)
      if (s2_wr && s2_a == s1_a && s2_bw[i]) fwd[i*LW +: LW] = wdata[i*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (rst_n && go && s2_wr)
      for (int i = 0; i < LANES; i++)
        if (s2_bw[i]) mem[s2_a][i*LW +: LW] <= wdata[i*LW +: LW];
  end

  assign rdata_oe = r_v && !oe_n;
  assign rdata    = rdata_oe ? r_d : '0;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(r_d) && $stable(r_v) && $stable(b_cnt) && $stable(s1_v))); // R2
  AST_LOAD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ld && !cs_n) |=> (s1_v && b_cnt == 2'd0 && s1_a == $past(addr))); // R3
  AST_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (go && s1_v && !s1_we) |=> r_v); // R4
  AST_WRITE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && s1_v && s1_we) |=> (s2_wr && s2_a == $past(s1_a))); // R5
  AST_SLEEP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (go && zz_q2) |=> !s1_v); // R11
  AST_DESEL_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !adv_ld && !zz_q2 && cs_n) |=> !b_act); // R10
endmodule

// File: tb/test_zt_sram.sv
`timescale 1ns/1ps
module test_zt_sram;
  logic        clk = 1'b0;
  logic        rst_n, cke_n, adv_ld, cs_n, we_n, lin_order, zz, oe_n;
  logic [3:0]  bw_n;
  logic [5:0]  addr;
  logic [71:0] wdata, rdata;
  logic        rdata_oe;

  always #4 clk = ~clk;

  zt_sram i_zt_sram (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld(adv_ld), .cs_n(cs_n),
    .we_n(we_n), .bw_n(bw_n), .addr(addr), .lin_order(lin_order), .zz(zz),
    .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  typedef struct {bit v; bit w; int a; bit [3:0] en;} mop_t;
  mop_t        ops[$];
  bit          zq[$];
  bit [71:0]   mm [64];
  bit          mv, bact, bwr, blk;
  bit [71:0]   md;
  int          bbase, bk, lo, n;
  int          checks = 0, failures = 0;
  string       tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      ops.delete(); zq.delete(); mv = 0; bact = 0;
    end else begin
      blk = (zq.size() >= 2) ? zq[1] : 1'b0;
      zq.push_front(zz);
      if (zq.size() > 2) void'(zq.pop_back());
      if (!cke_n) begin
        mop_t nop;
        n = ops.size();
        if (n >= 2 && ops[n-2].v && ops[n-2].w)
          for (int i = 0; i < 4; i++)
            if (ops[n-2].en[i]) mm[ops[n-2].a][i*18 +: 18] = wdata[i*18 +: 18];
        if (n >= 1 && ops[n-1].v && !ops[n-1].w) begin mv = 1; md = mm[ops[n-1].a]; end
        else mv = 0;
        nop = '{v: 0, w: 0, a: 0, en: 0};
        if (!blk) begin
          if (!adv_ld) begin
            if (cs_n) bact = 0;
            else begin
              bact = 1; bwr = !we_n; bbase = int'(addr); bk = 0;
              nop = '{v: 1, w: !we_n, a: int'(addr), en: ~bw_n};
            end
          end else if (bact) begin
            bk = (bk + 1) % 4;
            lo = lin_order ? (bbase + bk) % 4 : ((bbase % 4) ^ bk);
            nop = '{v: 1, w: bwr, a: (bbase / 4) * 4 + lo, en: ~bw_n};
          end
        end
        ops.push_back(nop);
        if (ops.size() > 3) void'(ops.pop_front());
      end
    end
  end

  task automatic tick();
    logic        eo;
    logic [71:0] ed;
    @(negedge clk);
    eo = mv && !oe_n;
    ed = eo ? md : 72'h0;
    checks++;
    if (rdata_oe !== eo || rdata !== ed) begin
      failures++;
      $display("FAIL %s t=%0t oe actual=%b expected=%b data actual=%h expected=%h",
               tag, $time, rdata_oe, eo, rdata, ed);
    end
  endtask

  task automatic drive(bit ld, bit cs, bit wr, int a, bit [3:0] bwn);
    adv_ld = !ld; cs_n = cs; we_n = !wr; addr = 6'(a); bw_n = bwn;
    wdata = {8'($urandom()), $urandom(), $urandom()};
    tick();
  endtask

  task automatic rnd(int span, int nc);
    for (int k = 0; k < nc; k++)
      drive($urandom % 3 != 0, $urandom % 8 == 0, $urandom % 2 == 1,
            $urandom % span, 4'($urandom));
  endtask

  initial begin
    rst_n = 0; cke_n = 0; adv_ld = 1; cs_n = 1; we_n = 1; bw_n = '1; addr = 0;
    lin_order = 1; zz = 0; oe_n = 0; wdata = '0;
    repeat (3) tick();
    checks++;
    if (rdata_oe !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset oe actual=%b expected=0", rdata_oe);
    end
    rst_n = 1;
    tag = "R1";
    repeat (3) drive(0, 0, 0, 0, 4'h0);
    tag = "R5";
    for (int a = 0; a < 64; a++) drive(1, 0, 1, a, 4'h0);
    repeat (2) drive(1, 1, 0, 0, 4'hf);
    tag = "R4";
    for (int a = 0; a < 16; a++) drive(1, 0, 0, a * 3, 4'hf);
    tag = "R5";
    for (int a = 0; a < 20; a++) drive(1, 0, $urandom % 2 == 1, $urandom % 8, 4'($urandom));
    tag = "R6";
    for (int k = 0; k < 20; k++) begin
      int a = $urandom % 64;
      drive(1, 0, 1, a, 4'($urandom));
      drive(1, 0, 0, a, 4'hf);
      drive(1, 0, 0, a, 4'hf);
    end
    tag = "R12";
    for (int k = 0; k < 60; k++) drive(1, 0, k % 2 == 0, $urandom % 6, 4'($urandom));
    for (int o = 0; o < 2; o++) begin
      lin_order = (o == 0);
      tag = (o == 0) ? "R8" : "R9";
      for (int b = 0; b < 8; b++) begin
        drive(1, 0, b % 2 == 0, 16 + b, 4'($urandom));
        repeat (5) drive(0, 0, 0, 0, 4'($urandom));
        drive(1, 0, 0, 16 + b, 4'hf);
        repeat (4) drive(0, 1, 1, 0, 4'hf);
      end
    end
    tag = "R10";
    for (int k = 0; k < 10; k++) begin
      drive(1, 0, 0, $urandom % 64, 4'hf);
      drive(1, 1, 0, 0, 4'hf);
      repeat (3) drive(0, 0, $urandom % 2 == 1, 0, 4'h0);
    end
    tag = "R3";
    rnd(8, 80);
    tag = "R2";
    for (int k = 0; k < 150; k++) begin
      cke_n = ($urandom % 3 == 0);
      drive($urandom % 3 != 0, $urandom % 8 == 0, $urandom % 2 == 1, $urandom % 8, 4'($urandom));
    end
    cke_n = 0;
    tag = "R7";
    for (int k = 0; k < 80; k++) begin
      oe_n = $urandom % 2 == 1;
      drive($urandom % 3 != 0, 0, $urandom % 2 == 1, $urandom % 8, 4'($urandom));
    end
    oe_n = 0;
    tag = "R11";
    for (int w = 0; w < 6; w++) begin
      rnd(8, 4);
      zz = 1;
      rnd(8, 3 + w);
      zz = 0;
      rnd(8, 6);
    end
    tag = "R12";
    for (int k = 0; k < 400; k++) begin
      cke_n = ($urandom % 6 == 0);
      oe_n  = ($urandom % 5 == 0);
      zz    = ($urandom % 20 == 0);
      lin_order = $urandom % 2 == 1;
      drive($urandom % 3 != 0, $urandom % 10 == 0, $urandom % 2 == 1, $urandom % 8, 4'($urandom));
    end
    cke_n = 0; oe_n = 0; zz = 0;
    rnd(8, 10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule